// File: doc/BRIEF.md
# Local-Buffer Byte DMA Engine

This block moves bytes between a 4 KiB on-chip buffer and host memory over one channel. Software programs a source address, a destination address and a byte count. A command write with the run bit set then starts the job. The engine waits a fixed number of clock cycles after that write. It then checks that the on-chip range falls inside the buffer window. If the range is legal, it issues one host request per byte until the count is used up, and the next byte goes out only after the host has accepted the current one.

The on-chip side is a fixed window with a configurable base (default 0x40000) and size (default 4096 bytes). The host-side start address is ANDed with a mask (default 0x0FFF_FFFF) before use. While a job is active every register is frozen. When the job ends, the run bit drops, and the engine can send a one-cycle completion interrupt request that carries the code 0x100. A range that breaks the window rules sets a sticky error flag instead.

Top module: `lbdma_engine`

## Requirements
- R1: Four 32-bit registers are decoded from `reg_addr`: source at 0x80, destination at 0x88, byte count at 0x90 and command at 0x98. A write takes effect only when `reg_size` is 4 or 8. `reg_rdata` shows the register when `reg_size` is 4 or 8 and the offset is one of these four. For any other offset or size it shows 0xFFFF_FFFF. All registers read 0 after reset.
- R2: In the command register, bit 0 is run. Bit 1 is direction: 0 moves host memory into the buffer and 1 moves the buffer out to host memory. Bit 2 enables the completion interrupt. The command register keeps only these three bits, and bits 31..3 read as 0.
- R3: While the run bit reads 1, writes to any of the four registers are ignored.
- R4: A command write with bit 0 clear is ignored entirely. The command register keeps its value and no host request follows.
- R5: `hm_req` first goes high exactly START_DELAY clock cycles after the clock edge that accepted the starting command write, and it is high only while the run bit is set.
- R6: The on-chip range runs from [local, local+count). The local address is the destination when bit 1 is 0 and the source when bit 1 is 1. The range is legal only if count > 0, local ≥ base, and local+count ≤ base+4096, computed without wrap. On an illegal range, `err_flag` sets and stays set until reset, no host request is made, the run bit clears, and no interrupt is raised.
- R7: For byte index i, the host address is (host start AND HOST_MASK) + i. The host start is the source when bit 1 is 0 and the destination when bit 1 is 1.
- R8: Exactly one byte moves on each rising edge where `hm_req` and `hm_ready` are both 1. Bytes go in ascending address order. While `hm_ready` is 0, `hm_req`, `hm_addr`, `hm_we` and `hm_wdata` hold their values. `hm_we` equals bit 1 while `hm_req` is high.
- R9: The run bit clears on the edge of the last byte's handshake. If bit 2 was set, `irq_req` is high for the following single cycle with `irq_code` = 0x0000_0100. Otherwise no pulse is raised. Bits 2..1 keep their values, and `irq_code` is 0 whenever `irq_req` is low.
- R10: A byte written into the buffer from host memory is returned unchanged when the same buffer address is later copied out to host memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from offset and size |
| hm_req | output | 1 | Host byte request |
| hm_we | output | 1 | 1 = write byte to host, 0 = read byte from host |
| hm_addr | output | 32 | Host byte address |
| hm_wdata | output | 8 | Byte sent to host |
| hm_rdata | input | 8 | Byte returned by host, valid in a cycle where `hm_ready` is high |
| hm_ready | input | 1 | Host accepts the current request |
| irq_req | output | 1 | One-cycle completion interrupt request |
| irq_code | output | 32 | Interrupt cause code, 0x100 during the pulse |
| err_flag | output | 1 | Sticky window-violation flag |

## Verification
The transfer path runs in both directions with several `hm_ready` patterns: always high, and a repeating two-of-three pattern. The stalled pattern separates correct holding of the request from advancing on a cycle where the host never accepted. A host start address with bits set above bit 27 separates masked from unmasked addressing. For the window check, three cases are used: a range that ends exactly at the top of the window, one that crosses the top, and one that starts below the base. Together they separate an inclusive from an exclusive end compare. A command write with the run bit clear, and writes issued mid-job, separate real locking from plain register updates.

// File: rtl/lbdma_pkg.sv
// Shared constants and types for the local-buffer DMA engine.
// Assumes byte-addressed register offsets and a 3-bit command field.
package lbdma_pkg;
    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFF_SRC = 8'h80;
    localparam logic [REG_AW-1:0] OFF_DST = 8'h88;
    localparam logic [REG_AW-1:0] OFF_CNT = 8'h90;
    localparam logic [REG_AW-1:0] OFF_CMD = 8'h98;

    localparam int CMD_RUN = 0;
    localparam int CMD_DIR = 1;
    localparam int CMD_IRQ = 2;
    localparam int CMD_W   = 3;

    localparam logic [31:0] DONE_IRQ_CODE = 32'h0000_0100;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MOVE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/lbdma_regs.sv
// Register block: source, destination, count and command.
// Writes are dropped while the run bit is set, or when the size is not 4 or 8.
// A command write with run = 0 is dropped. The run bit is cleared by the sequencer.
// Assumes the fin pulse can only arrive while run is set.
module lbdma_regs
    import lbdma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [3:0]        size,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              fin,
    output logic [DW-1:0]     src_q,
    output logic [DW-1:0]     dst_q,
    output logic [DW-1:0]     cnt_q,
    output logic              dir_q,
    output logic              irq_en_q,
    output logic              run_q,
    output logic              start
);
    logic [CMD_W-1:0] cmd_q;
    logic             size_ok;
    logic             wr_ok;

    // Decode the legal access sizes and the write acceptance.
    always_comb begin
        size_ok = (size == 4'd4) || (size == 4'd8);
        wr_ok   = wr_en && size_ok && !cmd_q[CMD_RUN];
        start   = wr_ok && (addr == OFF_CMD) && wdata[CMD_RUN];
    end

    // Register storage with lock and the run-bit clear at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
            cmd_q <= '0;
        end else begin
            if (wr_ok && addr == OFF_SRC) src_q <= wdata;
            if (wr_ok && addr == OFF_DST) dst_q <= wdata;
            if (wr_ok && addr == OFF_CNT) cnt_q <= wdata;
            if (start) begin
                cmd_q <= wdata[CMD_W-1:0];
            end else if (fin) begin
                cmd_q[CMD_RUN] <= 1'b0;
            end
        end
    end

    // Read mux: all ones for unknown offsets or sizes.
    always_comb begin
        rdata = '1;
        if (size_ok) begin
            case (addr)
                OFF_SRC: rdata = src_q;
                OFF_DST: rdata = dst_q;
                OFF_CNT: rdata = cnt_q;
                OFF_CMD: rdata = {{(DW-CMD_W){1'b0}}, cmd_q};
                default: rdata = '1;
            endcase
        end
    end

    // Command fields to the sequencer.
    always_comb begin
        run_q    = cmd_q[CMD_RUN];
        dir_q    = cmd_q[CMD_DIR];
        irq_en_q = cmd_q[CMD_IRQ];
    end
endmodule

// File: rtl/lbdma_seq.sv
// Transfer sequencer: counts the start delay, checks the window once,
// then issues one host byte request at a time until the count is used up.
// Assumes the register values stay stable while the job is active,
// which the register lock guarantees.
module lbdma_seq
    import lbdma_pkg::*;
#(
    parameter int            AW          = 32,
    parameter logic [AW-1:0] WIN_BASE    = 32'h0004_0000,
    parameter int            WIN_BYTES   = 4096,
    parameter logic [AW-1:0] HOST_MASK   = 32'h0FFF_FFFF,
    parameter int            START_DELAY = 8,
    localparam int           BUF_AW      = $clog2(WIN_BYTES),
    localparam int           DLY_W       = $clog2(START_DELAY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     src,
    input  logic [AW-1:0]     dst,
    input  logic [AW-1:0]     cnt,
    input  logic              dir,
    input  logic              irq_en,
    input  logic              hm_ready,
    output logic              hm_req,
    output logic              hm_we,
    output logic [AW-1:0]     hm_addr,
    output logic [BUF_AW-1:0] buf_idx,
    output logic              buf_we,
    output logic              fin,
    output logic              irq_req,
    output logic              err_flag
);
    localparam logic [AW:0] WIN_LO = {1'b0, WIN_BASE};
    localparam logic [AW:0] WIN_HI = WIN_LO + (AW+1)'(WIN_BYTES);

    seq_state_t       st;
    logic [DLY_W-1:0] dly;
    logic [AW-1:0]    idx;

    logic [AW-1:0] loc_base;
    logic [AW-1:0] host_base;
    logic [AW:0]   lo_ext;
    logic [AW:0]   end_ext;
    logic          range_ok;
    logic          step;
    logic          last;
    logic          decide;

    // Select the local and host sides and check the window without wrap.
    always_comb begin
        loc_base  = dir ? src : dst;
        host_base = dir ? dst : src;
        lo_ext    = {1'b0, loc_base};
        end_ext   = lo_ext + {1'b0, cnt};
        range_ok  = (lo_ext >= WIN_LO) && (end_ext > lo_ext) && (end_ext <= WIN_HI);
    end

    // Per-cycle handshake and completion decode.
    always_comb begin
        step    = (st == ST_MOVE) && hm_ready;
        last    = (idx == cnt - 1'b1);
        decide  = (st == ST_WAIT) && (dly == '0);
        fin     = (step && last) || (decide && !range_ok);
        hm_req  = (st == ST_MOVE);
        hm_we   = (st == ST_MOVE) && dir;
        hm_addr = (host_base & HOST_MASK) + idx;
        buf_idx = BUF_AW'(loc_base - WIN_BASE + idx);
        buf_we  = step && !dir;
    end

    // State, delay counter, byte index, interrupt pulse and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            dly      <= '0;
            idx      <= '0;
            irq_req  <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            irq_req <= step && last && irq_en;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st  <= ST_WAIT;
                        dly <= DLY_W'(START_DELAY - 1);
                    end
                end
                ST_WAIT: begin
                    if (dly == '0) begin
                        if (range_ok) begin
                            st  <= ST_MOVE;
                            idx <= '0;
                        end else begin
                            st       <= ST_IDLE;
                            err_flag <= 1'b1;
                        end
                    end else begin
                        dly <= dly - 1'b1;
                    end
                end
                ST_MOVE: begin
                    if (step) begin
                        idx <= idx + 1'b1;
                        if (last) st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lbdma_buf.sv
// Local byte buffer: one synchronous write port and a combinational read
// at the same index. Contents are not reset.
module lbdma_buf #(
    parameter int  DEPTH = 4096,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Store a byte on a handshake from the host side.
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    // Present the byte at the current index to the host write path.
    always_comb rdata = mem[idx];
endmodule

// File: rtl/lbdma_engine.sv
// Top of the local-buffer DMA engine: register block, sequencer and buffer.
// Assumes one register access per cycle and a host that returns read data
// in the same cycle it raises hm_ready.
module lbdma_engine
    import lbdma_pkg::*;
#(
    parameter int            AW          = 32,
    parameter logic [AW-1:0] WIN_BASE    = 32'h0004_0000,
    parameter int            WIN_BYTES   = 4096,
    parameter logic [AW-1:0] HOST_MASK   = 32'h0FFF_FFFF,
    parameter int            START_DELAY = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [3:0]        reg_size,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    output logic              hm_req,
    output logic              hm_we,
    output logic [AW-1:0]     hm_addr,
    output logic [7:0]        hm_wdata,
    input  logic [7:0]        hm_rdata,
    input  logic              hm_ready,
    output logic              irq_req,
    output logic [31:0]       irq_code,
    output logic              err_flag
);
    localparam int BUF_AW = $clog2(WIN_BYTES);

    logic [AW-1:0]     src_q, dst_q, cnt_q;
    logic              dir_q, irq_en_q, run_q, start, fin;
    logic [BUF_AW-1:0] buf_idx;
    logic              buf_we;

    lbdma_regs #(.DW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .size     (reg_size),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .fin      (fin),
        .src_q    (src_q),
        .dst_q    (dst_q),
        .cnt_q    (cnt_q),
        .dir_q    (dir_q),
        .irq_en_q (irq_en_q),
        .run_q    (run_q),
        .start    (start)
    );

    lbdma_seq #(
        .AW          (AW),
        .WIN_BASE    (WIN_BASE),
        .WIN_BYTES   (WIN_BYTES),
        .HOST_MASK   (HOST_MASK),
        .START_DELAY (START_DELAY)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .src      (src_q),
        .dst      (dst_q),
        .cnt      (cnt_q),
        .dir      (dir_q),
        .irq_en   (irq_en_q),
        .hm_ready (hm_ready),
        .hm_req   (hm_req),
        .hm_we    (hm_we),
        .hm_addr  (hm_addr),
        .buf_idx  (buf_idx),
        .buf_we   (buf_we),
        .fin      (fin),
        .irq_req  (irq_req),
        .err_flag (err_flag)
    );

    lbdma_buf #(.DEPTH(WIN_BYTES)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .idx   (buf_idx),
        .wdata (hm_rdata),
        .rdata (hm_wdata)
    );

    // The cause code is driven only during the completion pulse.
    always_comb irq_code = irq_req ? DONE_IRQ_CODE : 32'h0;
endmodule

// File: rtl/lbdma_chk.sv
// Property checker for lbdma_engine, attached by bind below.
// Assumes the top-level signal names of lbdma_engine.
module lbdma_chk
    import lbdma_pkg::*;
#(
    parameter int            AW        = 32,
    parameter logic [AW-1:0] HOST_MASK = 32'h0FFF_FFFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic              run,
    input logic              dir,
    input logic [AW-1:0]     src_q,
    input logic [AW-1:0]     dst_q,
    input logic              hm_req,
    input logic              hm_ready,
    input logic              hm_we,
    input logic [AW-1:0]     hm_addr,
    input logic [7:0]        hm_wdata,
    input logic              irq_req,
    input logic [31:0]       irq_code,
    input logic              err_flag
);
    // R3: a source write during a job leaves the source unchanged.
    p_lock_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && reg_wr && reg_addr == OFF_SRC) |=> $stable(src_q));

    // R5: host requests occur only while the run bit is set.
    p_req_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hm_req |-> run);

    // R7: the first request of a job uses the masked host start.
    p_mask_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hm_req) |-> (hm_addr == ((dir ? dst_q : src_q) & HOST_MASK)));

    // R8: a request not accepted is held unchanged.
    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hm_req && !hm_ready) |=> (hm_req && $stable(hm_addr) && $stable(hm_we) && $stable(hm_wdata)));

    // R9: the interrupt pulse follows the run bit falling and carries its code.
    p_irq_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ($fell(run) && irq_code == DONE_IRQ_CODE));

    // R9: the interrupt pulse lasts one cycle.
    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);

    // R6: the error flag never clears once set.
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R6: the error ends the job with no host request.
    p_err_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> (!hm_req && $fell(run)));
endmodule

bind lbdma_engine lbdma_chk #(.AW(AW), .HOST_MASK(HOST_MASK)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .run      (run_q),
    .dir      (dir_q),
    .src_q    (src_q),
    .dst_q    (dst_q),
    .hm_req   (hm_req),
    .hm_ready (hm_ready),
    .hm_we    (hm_we),
    .hm_addr  (hm_addr),
    .hm_wdata (hm_wdata),
    .irq_req  (irq_req),
    .irq_code (irq_code),
    .err_flag (err_flag)
);

// File: tb/sim_lbdma_engine.sv
// Bench for lbdma_engine: a behavioural reference model advanced on every
// rising edge and compared with the outputs on every falling edge, plus
// directed checks.
module sim_lbdma_engine;
    localparam int          DLY  = 8;
    localparam logic [31:0] MASK = 32'h0FFF_FFFF;
    localparam logic [31:0] WB   = 32'h0004_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [3:0]  reg_size = 4'd4;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hm_req, hm_we;
    logic [31:0] hm_addr;
    logic [7:0]  hm_wdata, hm_rdata;
    logic        hm_ready = 1'b1;
    logic        irq_req;
    logic [31:0] irq_code;
    logic        err_flag;

    always #10 clk = ~clk;

    lbdma_engine #(.START_DELAY(DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hm_req(hm_req), .hm_we(hm_we), .hm_addr(hm_addr), .hm_wdata(hm_wdata),
        .hm_rdata(hm_rdata), .hm_ready(hm_ready), .irq_req(irq_req),
        .irq_code(irq_code), .err_flag(err_flag)
    );

    // Host memory seen by the engine (low 12 address bits).
    logic [7:0] hmem [4096];
    assign hm_rdata = hmem[hm_addr[11:0]];

    int n_chk = 0, n_fail = 0, cyc = 0, n_hs = 0, n_irq = 0, stall_ctr = 0;
    bit rdy_pat = 1'b0;
    bit done_flag = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model state.
    bit [31:0] m_src, m_dst, m_cnt;
    bit [2:0]  m_cmd;
    int        m_ph, m_wait, m_idx;
    bit        m_err, m_irq;
    logic [7:0] lbuf [4096];

    function automatic logic [31:0] m_host_addr();
        return ((m_cmd[1] ? m_dst : m_src) & MASK) + 32'(m_idx);
    endfunction
    function automatic int m_loc_idx();
        return int'(((m_cmd[1] ? m_src : m_dst) - WB + 32'(m_idx)) & 32'hFFF);
    endfunction

    // Model advance and host memory behaviour on each rising edge.
    always @(posedge clk) begin : mdl
        bit        run_b;
        longint    lo, hi;
        if (!rst_n) begin
            m_src = 0; m_dst = 0; m_cnt = 0; m_cmd = 0;
            m_ph = 0; m_wait = 0; m_idx = 0; m_err = 0; m_irq = 0;
        end else begin
            run_b = m_cmd[0];
            m_irq = 1'b0;
            if (hm_req && hm_ready) begin
                n_hs++;
                if (hm_we) hmem[hm_addr[11:0]] = hm_wdata;
            end
            if (m_ph == 2 && hm_ready) begin
                if (!m_cmd[1]) lbuf[m_loc_idx()] = hmem[m_host_addr() & 32'hFFF];
                m_idx++;
                if (32'(m_idx) == m_cnt) begin
                    m_ph = 0; m_cmd[0] = 1'b0; m_irq = m_cmd[2];
                end
            end else if (m_ph == 1) begin
                if (m_wait == 0) begin
                    lo = longint'(m_cmd[1] ? m_src : m_dst);
                    hi = lo + longint'(m_cnt);
                    if (lo >= longint'(WB) && hi > lo && hi <= longint'(WB) + 4096) begin
                        m_ph = 2; m_idx = 0;
                    end else begin
                        m_ph = 0; m_err = 1'b1; m_cmd[0] = 1'b0;
                    end
                end else begin
                    m_wait--;
                end
            end
            if (reg_wr && (reg_size == 4 || reg_size == 8) && !run_b) begin
                case (reg_addr)
                    8'h80: m_src = reg_wdata;
                    8'h88: m_dst = reg_wdata;
                    8'h90: m_cnt = reg_wdata;
                    8'h98: if (reg_wdata[0]) begin
                        m_cmd = reg_wdata[2:0]; m_ph = 1; m_wait = DLY - 1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Compare the outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            check("R5 request timing", {31'b0, hm_req}, {31'b0, m_ph == 2});
            if (m_ph == 2) begin
                check("R7 host address", hm_addr, m_host_addr());
                check("R8 direction", {31'b0, hm_we}, {31'b0, m_cmd[1]});
                if (m_cmd[1]) check("R10 outgoing byte", {24'b0, hm_wdata}, {24'b0, lbuf[m_loc_idx()]});
            end
            check("R9 interrupt pulse", {31'b0, irq_req}, {31'b0, m_irq});
            check("R9 interrupt code", irq_code, m_irq ? 32'h100 : 32'h0);
            check("R6 error flag", {31'b0, err_flag}, {31'b0, m_err});
            if (irq_req) n_irq++;
        end
        stall_ctr++;
        hm_ready <= rdy_pat ? ((stall_ctr % 3) != 2) : 1'b1;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done_flag) begin
            done_flag = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_size = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [3:0] s, output logic [31:0] d);
        reg_addr = a; reg_size = s;
        #2;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            rd(8'h98, 4'd4, v);
            if (!v[0]) break;
        end
    endtask

    initial begin : stim
        logic [31:0] v;
        int n, hs0, irq0;
        for (int i = 0; i < 4096; i++) hmem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of registers and outputs.
        rd(8'h80, 4'd4, v); check("R1 reset source", v, 32'h0);
        rd(8'h98, 4'd4, v); check("R1 reset command", v, 32'h0);
        check("R9 reset irq", {31'b0, irq_req}, 32'h0);
        check("R6 reset error", {31'b0, err_flag}, 32'h0);

        // R1: sizes and offsets.
        wr(8'h80, 4'd4, 32'h1234_5678); rd(8'h80, 4'd4, v); check("R1 source 4-byte", v, 32'h1234_5678);
        wr(8'h88, 4'd8, 32'hAAAA_5555); rd(8'h88, 4'd8, v); check("R1 destination 8-byte", v, 32'hAAAA_5555);
        wr(8'h90, 4'd2, 32'h0000_DEAD); rd(8'h90, 4'd4, v); check("R1 count bad size ignored", v, 32'h0);
        rd(8'h84, 4'd4, v); check("R1 unknown offset", v, 32'hFFFF_FFFF);
        rd(8'h80, 4'd2, v); check("R1 bad read size", v, 32'hFFFF_FFFF);

        // R4: command without run is ignored.
        hs0 = n_hs;
        wr(8'h98, 4'd4, 32'h0000_0006);
        rd(8'h98, 4'd4, v); check("R4 command unchanged", v, 32'h0);
        repeat (DLY + 4) @(negedge clk);
        check("R4 no host traffic", 32'(n_hs - hs0), 32'h0);

        // Host to buffer with stalls and a masked host address.
        rdy_pat = 1'b1;
        irq0 = n_irq;
        wr(8'h80, 4'd4, 32'hF000_0010);
        wr(8'h88, 4'd4, 32'h0004_0020);
        wr(8'h90, 4'd4, 32'd16);
        wr(8'h98, 4'd4, 32'hFFFF_FFF5);
        rd(8'h98, 4'd4, v); check("R2 command keeps three bits", v, 32'h5);
        n = 0;
        while (!hm_req && n < 50) begin @(negedge clk); n++; end
        check("R5 start delay", 32'(n), 32'(DLY));
        check("R7 masked start", hm_addr, 32'h0000_0010);
        wr(8'h80, 4'd4, 32'h0);
        wr(8'h98, 4'd4, 32'h3);
        rd(8'h80, 4'd4, v); check("R3 source locked", v, 32'hF000_0010);
        rd(8'h98, 4'd4, v); check("R3 command locked", v, 32'h5);
        wait_idle();
        @(negedge clk);
        check("R9 one interrupt", 32'(n_irq - irq0), 32'h1);
        rd(8'h98, 4'd4, v); check("R9 run cleared", v, 32'h4);

        // R10: buffer back out to host memory, no interrupt requested.
        rdy_pat = 1'b0;
        irq0 = n_irq;
        wr(8'h80, 4'd4, 32'h0004_0020);
        wr(8'h88, 4'd4, 32'h0000_0200);
        wr(8'h98, 4'd4, 32'h3);
        wait_idle();
        repeat (2) @(negedge clk);
        for (int i = 0; i < 16; i++)
            check("R10 round trip", {24'b0, hmem[12'h200 + 12'(i)]}, {24'b0, 8'((16 + i) * 7 + 3)});
        check("R9 no interrupt when disabled", 32'(n_irq - irq0), 32'h0);
        rd(8'h98, 4'd4, v); check("R9 fields kept", v, 32'h2);

        // R6: range crossing the top of the window.
        hs0 = n_hs;
        wr(8'h88, 4'd4, 32'h0004_0FFE);
        wr(8'h90, 4'd4, 32'd4);
        wr(8'h98, 4'd4, 32'h5);
        repeat (DLY + 3) @(negedge clk);
        check("R6 error set", {31'b0, err_flag}, 32'h1);
        check("R6 no traffic", 32'(n_hs - hs0), 32'h0);
        rd(8'h98, 4'd4, v); check("R6 run cleared", v, 32'h4);

        // R6: range ending exactly at the top is legal.
        hs0 = n_hs;
        wr(8'h80, 4'd4, 32'h0000_0300);
        wr(8'h88, 4'd4, 32'h0004_0FFC);
        wr(8'h98, 4'd4, 32'h1);
        wait_idle();
        check("R6 exact fit moves four bytes", 32'(n_hs - hs0), 32'h4);
        check("R6 error stays set", {31'b0, err_flag}, 32'h1);

        // R6: start below the base, and a zero count.
        hs0 = n_hs;
        wr(8'h88, 4'd4, 32'h0003_FFFF);
        wr(8'h98, 4'd4, 32'h1);
        wait_idle();
        wr(8'h88, 4'd4, 32'h0004_0000);
        wr(8'h90, 4'd4, 32'h0);
        wr(8'h98, 4'd4, 32'h1);
        wait_idle();
        check("R6 rejected ranges move nothing", 32'(n_hs - hs0), 32'h0);

        repeat (3) @(negedge clk);
        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule